// File: doc/BRIEF.md
# PDM Audio DAC Output Stage with Guard-Bit Saturation

This block turns a written audio sample into a one-bit pulse-density stream for an external loudspeaker driver. A 16-bit sample word carries a 10-bit magnitude and two guard bits that sit directly above it. A first-order error-accumulating modulator adds the magnitude to a running remainder on every PDM step and sends out the carry, so the density of ones follows the magnitude. When either guard bit is set, the stage holds its output at full drive instead of letting an oversized sample wrap to a small value.

A rate bit chooses between one PDM step per master clock and one step every second master clock. At half rate a two-state phase machine (`PH_IDLE` and `PH_FIRE`) alternates every clock, and a step fires in `PH_FIRE`. At full rate every clock is a step. The modulator is a two-state machine. In `MS_TRACK` it runs the accumulator loop. It moves to `MS_SATURATE` on a step whose sample has a guard bit set while the guard format is active. It returns to `MS_TRACK` on the first step whose sample no longer asks for saturation, and that return step starts from a cleared remainder. A format bit selects an alternate sample format in which the guard bits are ignored.

All three settings are held in registers written through strobes. A write changes nothing until the next PDM step, and the output changes only on a step.

Top module: `pdm_dac_stage`

## Requirements
- R1: After reset, `pdm_out` is 0, the guard format is selected (format bit 0), and the half rate is selected (rate bit 0).
- R2: With rate bit 0, `pdm_tick` is 1 on every second clock, so a window of 20 clocks holds exactly 10 steps. The first clock after reset has no step.
- R3: With rate bit 1, `pdm_tick` is 1 on every clock.
- R4: The magnitude is taken from `data_in[12:3]` (0 to 1023). Over 1024 steps that start from a cleared remainder, the number of ones on `pdm_out` equals the magnitude.
- R5: On each step in tracking mode, `pdm_out` becomes the carry out of bit 10 of the sum of the 10-bit remainder and the magnitude, and the remainder keeps the low 10 bits of that sum.
- R6: With format bit 0, a sample with bit 14 or bit 13 set (any magnitude above 1023 up to 4095 in bits 14:3) drives `pdm_out` to 1 on every step.
- R7: The first step after saturation ends uses a remainder of 0. For a magnitude below 1024, that step outputs 0 and leaves the remainder equal to the magnitude.
- R8: With format bit 1, bits 14:13 are ignored and no saturation occurs. The magnitude from bits 12:3 is modulated as in R5.
- R9: `pdm_out` changes only on a step. A register write takes effect from the first step after the write's clock edge.
- R10: Bits 15 and 2:0 of the sample word have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_we | input | 1 | Sample word write strobe |
| data_in | input | 16 | Sample word: guard bits 14:13, magnitude 12:3 |
| fmt_we | input | 1 | Format bit write strobe |
| fmt_in | input | 1 | Format: 0 guard-bit format, 1 alternate format |
| rate_we | input | 1 | Rate bit write strobe |
| rate_in | input | 1 | Rate: 0 half master clock, 1 full master clock |
| pdm_tick | output | 1 | High in each clock that ends with a PDM step |
| pdm_out | output | 1 | Pulse-density output |

## Verification
The hardest case to reach from the ports is leaving saturation while the remainder holds a large left-over value. If the clearing were missing, the long-run count of ones would still come out right, because a stale remainder shifts the count by less than one per 1024 steps. The stimulus therefore runs a mid-range sample long enough to leave a remainder near the top of its range, then forces saturation with a guard bit, and then writes the same sample again. The bench checks the first step after the return on its own and compares every later step with its prediction. Rate changes and format changes are placed between these phases, so the same return to tracking is also exercised at full rate and from the alternate format.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;

    // modulator operating mode
    typedef enum logic {
        MS_TRACK    = 1'b0,
        MS_SATURATE = 1'b1
    } mod_state_t;

    // half-rate step phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_FIRE = 1'b1
    } phase_t;

endpackage

// File: rtl/pdm_rate_gen.sv
module pdm_rate_gen
    import pdm_dac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rate_full,
    output logic step
);

    phase_t phase_q;
    phase_t phase_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // next phase: alternate every master clock
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: phase_d = PH_FIRE;
            PH_FIRE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // output: every clock at full rate, fire phase only at half rate
    always_comb begin
        step = rate_full || (phase_q == PH_FIRE);
    end

endmodule

// File: rtl/pdm_ctrl_regs.sv
module pdm_ctrl_regs #(
    parameter int DATA_W  = 16,
    parameter int MAG_W   = 10,
    parameter int MAG_LSB = 3,
    parameter int GUARD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    input  logic              fmt_we,
    input  logic              fmt_in,
    input  logic              rate_we,
    input  logic              rate_in,
    output logic [MAG_W-1:0]  mag,
    output logic              sat_req,
    output logic              fmt_alt,
    output logic              rate_full
);

    localparam int GUARD_LSB = MAG_LSB + MAG_W;
    localparam int TOP_USED  = GUARD_LSB + GUARD_W;

    logic [DATA_W-1:0]  data_q;
    logic [GUARD_W-1:0] guard;
    logic               unused_fields;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            fmt_alt   <= 1'b0;
            rate_full <= 1'b0;
        end else begin
            if (data_we) begin
                data_q <= data_in;
            end
            if (fmt_we) begin
                fmt_alt <= fmt_in;
            end
            if (rate_we) begin
                rate_full <= rate_in;
            end
        end
    end

    always_comb begin
        mag     = data_q[MAG_LSB +: MAG_W];
        guard   = data_q[GUARD_LSB +: GUARD_W];
        sat_req = !fmt_alt && (|guard);
    end

    // bits outside the magnitude and guard fields carry nothing
    assign unused_fields = ^{data_q[DATA_W-1:TOP_USED], data_q[MAG_LSB-1:0]};

endmodule

// File: rtl/pdm_modulator.sv
module pdm_modulator
    import pdm_dac_pkg::*;
#(
    parameter int MAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [MAG_W-1:0] mag,
    input  logic             sat_req,
    output logic             pdm_out,
    output mod_state_t       state,
    output logic [MAG_W-1:0] acc
);

    localparam int SUM_W = MAG_W + 1;

    mod_state_t       state_q;
    mod_state_t       state_d;
    logic [MAG_W-1:0] acc_q;
    logic [MAG_W-1:0] base;
    logic [SUM_W-1:0] sum;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions, evaluated only on a PDM step
    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                MS_TRACK:    if (sat_req)  state_d = MS_SATURATE;
                MS_SATURATE: if (!sat_req) state_d = MS_TRACK;
                default:     state_d = MS_TRACK;
            endcase
        end
    end

    // remainder restarts from zero on the step that leaves saturation
    always_comb begin
        base = (state_q == MS_SATURATE) ? '0 : acc_q;
        sum  = {1'b0, base} + {1'b0, mag};
    end

    // outputs: carry bit or full drive, updated on steps only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdm_out <= 1'b0;
            acc_q   <= '0;
        end else if (step) begin
            if (sat_req) begin
                pdm_out <= 1'b1;
            end else begin
                pdm_out <= sum[MAG_W];
                acc_q   <= sum[MAG_W-1:0];
            end
        end
    end

    assign state = state_q;
    assign acc   = acc_q;

endmodule

// File: rtl/pdm_dac_stage.sv
module pdm_dac_stage
    import pdm_dac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MAG_W   = 10,
    parameter int MAG_LSB = 3,
    parameter int GUARD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    input  logic              fmt_we,
    input  logic              fmt_in,
    input  logic              rate_we,
    input  logic              rate_in,
    output logic              pdm_tick,
    output logic              pdm_out
);

    logic [MAG_W-1:0] mag;
    logic             sat_req;
    logic             fmt_alt_q;
    logic             rate_full_q;
    mod_state_t       mod_state;
    logic [MAG_W-1:0] acc_q;

    pdm_ctrl_regs #(
        .DATA_W  (DATA_W),
        .MAG_W   (MAG_W),
        .MAG_LSB (MAG_LSB),
        .GUARD_W (GUARD_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_we   (data_we),
        .data_in   (data_in),
        .fmt_we    (fmt_we),
        .fmt_in    (fmt_in),
        .rate_we   (rate_we),
        .rate_in   (rate_in),
        .mag       (mag),
        .sat_req   (sat_req),
        .fmt_alt   (fmt_alt_q),
        .rate_full (rate_full_q)
    );

    pdm_rate_gen u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_full (rate_full_q),
        .step      (pdm_tick)
    );

    pdm_modulator #(
        .MAG_W (MAG_W)
    ) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (pdm_tick),
        .mag     (mag),
        .sat_req (sat_req),
        .pdm_out (pdm_out),
        .state   (mod_state),
        .acc     (acc_q)
    );

endmodule

// File: rtl/pdm_dac_stage_chk.sv
module pdm_dac_stage_chk
    import pdm_dac_pkg::*;
#(
    parameter int MAG_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pdm_tick,
    input logic             pdm_out,
    input logic             rate_full,
    input logic             fmt_alt,
    input logic             sat_req,
    input logic [MAG_W-1:0] mag,
    input logic [MAG_W-1:0] acc,
    input mod_state_t       mod_state
);

    // R9: output holds between steps
    a_r9_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !pdm_tick |=> $stable(pdm_out));

    // R2: at half rate a step is followed by a clock without a step
    a_r2_half_rate_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_full && pdm_tick) |=> (!pdm_tick || rate_full));

    // R3: full rate steps on every clock
    a_r3_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        rate_full |-> pdm_tick);

    // R6: a step with a guard bit set gives full drive
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (pdm_tick && sat_req) |=> pdm_out);

    // R7: leaving saturation starts from an empty remainder
    a_r7_exit_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_state == MS_SATURATE && pdm_tick && !sat_req)
        |=> (!pdm_out && acc == $past(mag)));

    // R8: the alternate format never enters saturation
    a_r8_alt_no_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (pdm_tick && fmt_alt) |=> (mod_state == MS_TRACK));

endmodule

bind pdm_dac_stage pdm_dac_stage_chk #(.MAG_W(MAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pdm_tick  (pdm_tick),
    .pdm_out   (pdm_out),
    .rate_full (rate_full_q),
    .fmt_alt   (fmt_alt_q),
    .sat_req   (sat_req),
    .mag       (mag),
    .acc       (acc_q),
    .mod_state (mod_state)
);

// File: tb/test_pdm_dac_stage.sv
module test_pdm_dac_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_we = 1'b0;
    logic [15:0] data_in = '0;
    logic        fmt_we = 1'b0;
    logic        fmt_in = 1'b0;
    logic        rate_we = 1'b0;
    logic        rate_in = 1'b0;
    logic        pdm_tick;
    logic        pdm_out;

    always #5 clk = ~clk;

    pdm_dac_stage i_pdm_dac_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_we  (data_we),
        .data_in  (data_in),
        .fmt_we   (fmt_we),
        .fmt_in   (fmt_in),
        .rate_we  (rate_we),
        .rate_in  (rate_in),
        .pdm_tick (pdm_tick),
        .pdm_out  (pdm_out)
    );

    int n_vec = 0;
    int n_bad = 0;
    int ones_cnt = 0;
    int step_cnt = 0;

    // scoreboard queue and reference state
    bit          exp_q[$];
    logic [15:0] m_data = '0;
    bit          m_fmt = 1'b0;
    logic [9:0]  m_acc = '0;
    bit          m_sat = 1'b0;
    bit          last_out = 1'b0;
    bit          mon_e;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // predict one step from the register values in force before the step edge
    task automatic predict_step();
        logic [10:0] sum;
        bit          sat;
        sat = !m_fmt && (m_data[14:13] != 2'b00);
        if (sat) begin
            exp_q.push_back(1'b1);
            m_sat = 1'b1;
        end else begin
            sum = (m_sat ? 11'd0 : {1'b0, m_acc}) + {1'b0, m_data[12:3]};
            exp_q.push_back(sum[10]);
            m_acc = sum[9:0];
            m_sat = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && pdm_tick) predict_step();
    end

    // mirror register writes
    always @(posedge clk) begin
        if (rst_n) begin
            if (data_we) m_data <= data_in;
            if (fmt_we)  m_fmt  <= fmt_in;
        end
    end

    // monitor: compare each step, check hold otherwise
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            check(pdm_out === mon_e, "R5 step output", int'(pdm_out), int'(mon_e));
            step_cnt++;
            if (pdm_out) ones_cnt++;
            last_out = pdm_out;
        end else if (rst_n) begin
            check(pdm_out === last_out, "R9 hold between steps", int'(pdm_out), int'(last_out));
        end
    end

    task automatic write_data(input logic [15:0] v);
        @(negedge clk);
        data_we = 1'b1;
        data_in = v;
        @(negedge clk);
        data_we = 1'b0;
        ones_cnt = 0;
        step_cnt = 0;
    endtask

    task automatic write_fmt(input bit v);
        @(negedge clk);
        fmt_we = 1'b1;
        fmt_in = v;
        @(negedge clk);
        fmt_we = 1'b0;
    endtask

    task automatic write_rate(input bit v);
        @(negedge clk);
        rate_we = 1'b1;
        rate_in = v;
        @(negedge clk);
        rate_we = 1'b0;
    endtask

    task automatic run_steps(input int n);
        while (step_cnt < n) @(negedge clk);
    endtask

    // saturate so the next sample starts from a cleared remainder
    task automatic clean();
        write_data(16'h6000);
        run_steps(4);
    endtask

    task automatic measure(input logic [15:0] v, input int exp_ones, input string req);
        clean();
        write_data(v);
        run_steps(1024);
        check(ones_cnt == exp_ones, req, ones_cnt, exp_ones);
    endtask

    task automatic count_ticks(input int exp_n, input string req);
        int c;
        c = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pdm_tick) c++;
        end
        check(c == exp_n, req, c, exp_n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(pdm_out === 1'b0, "R1 reset output", int'(pdm_out), 0);
        check(pdm_tick === 1'b0, "R1 first clock has no step", int'(pdm_tick), 0);
        // R2: half rate by default
        count_ticks(10, "R2 half rate steps in 20 clocks");

        // R4: density at half rate
        measure(16'd0 << 3,    0,    "R4 magnitude 0");
        measure(16'd1 << 3,    1,    "R4 magnitude 1");
        measure(16'd512 << 3,  512,  "R4 magnitude 512");
        measure(16'd1023 << 3, 1023, "R4 magnitude 1023");

        // R6: guard bits force full drive
        write_data(16'h4000 | (16'd5 << 3));
        run_steps(64);
        check(ones_cnt == 64, "R6 bit 14 saturates", ones_cnt, 64);
        write_data(16'h2000);
        run_steps(64);
        check(ones_cnt == 64, "R6 bit 13 saturates", ones_cnt, 64);
        write_data(16'd4095 << 3);
        run_steps(64);
        check(ones_cnt == 64, "R6 magnitude 4095 saturates", ones_cnt, 64);

        // R7: leave saturation with a large stale remainder
        write_data(16'd300 << 3);
        run_steps(37);
        write_data(16'h6000);
        run_steps(3);
        write_data(16'd300 << 3);
        run_steps(1);
        check(ones_cnt == 0, "R7 first step after saturation", ones_cnt, 0);
        run_steps(1024);
        check(ones_cnt == 300, "R7 count after saturation", ones_cnt, 300);

        // R10: bits outside the fields are ignored
        measure(16'h8000 | (16'd700 << 3) | 16'h0007, 700, "R10 stray bits ignored");

        // R3: full rate
        write_rate(1'b1);
        count_ticks(20, "R3 full rate steps in 20 clocks");
        measure(16'd341 << 3, 341, "R4 magnitude 341 full rate");
        write_data(16'd900 << 3);
        run_steps(29);
        write_data(16'h6000);
        run_steps(2);
        write_data(16'd900 << 3);
        run_steps(1);
        check(ones_cnt == 0, "R7 clean exit at full rate", ones_cnt, 0);

        // R8: alternate format ignores guard bits
        clean();
        write_fmt(1'b1);
        write_data(16'h6000 | (16'd256 << 3));
        run_steps(1024);
        check(ones_cnt == 256, "R8 alternate format no saturation", ones_cnt, 256);
        write_fmt(1'b0);
        write_data(16'h2000 | (16'd256 << 3));
        run_steps(16);
        check(ones_cnt == 16, "R8 guard format restored", ones_cnt, 16);

        // R9: back to half rate, holds checked by the monitor
        write_rate(1'b0);
        count_ticks(10, "R2 half rate after switching back");
        measure(16'd77 << 3, 77, "R4 magnitude 77 half rate");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule